// File: doc/BRIEF.md
# Multi-Operand Multiple-Valued Digit Adder

This block adds several digits of one radix, each held as a binary integer, in a single step. It returns a carry digit and a sum digit, and also the radix complement of each. It does not divide. The carry is the number of comparator thresholds that the input total reaches, on a ladder that rises in steps of the radix. The sum comes from a second ladder, which is applied to the total plus the radix times the complemented carry. This step removes the carry's weight from the total without a subtractor. The ladder thresholds are fixed when the block is built.

The number of digits can be any value from 2 up to one more than the radix, and the carry still fits in one digit. A build parameter chooses one of two digit formats. In the unbalanced format, digits run from 0 to R-1. In the balanced format, the radix must be odd and digits are symmetric about zero. A second parameter chooses one of two output paths. One is a registered stage with valid/ready flow control. The other is a direct combinational path in which the handshake passes straight through. Build-time checks reject any of the following:
- a radix below 2
- fewer than 2 digits
- more than R+1 digits
- balanced format with an even radix

Flow control (registered path): a word is taken when `in_valid` and `in_ready` are both high at a clock edge. A result, once presented, stays fixed until `out_ready` is seen high. While a result is waiting, no new word is taken.

Top module: `mv_digit_adder`

## Requirements
- R1: In unbalanced format the carry is the greatest i in 1..R-1 for which R*i is less than or equal to the total of the digits, or 0 if none qualifies. For R=3 a total of 7 gives carry 2, and a total of 4 gives carry 1.
- R2: The carry complement is R-1-carry in unbalanced format. In balanced format it is the two's complement negation of the carry.
- R3: In unbalanced format the sum is the greatest i in 1..R-1 for which R*R-R+i is less than or equal to the total plus R times the carry complement, or 0 if none qualifies. It follows that total = R*carry + sum.
- R4: The sum complement is R-1-sum in unbalanced format and the negation of the sum in balanced format.
- R5: Balanced format uses the following rules:
  - Each digit is two's complement, ceil(log2 R)+1 bits wide.
  - The carry is floor((total+(R-1)/2)/R).
  - The sum is the total plus R times the carry complement, and it lies in -(R-1)/2..(R-1)/2.
- R6: Input digit j occupies bits j*DW +: DW. `out_err` is high for a word if any digit lies outside the legal range. In unbalanced format the range is 0..R-1, and each digit is ceil(log2 R) bits wide. In balanced format the range is -(R-1)/2..(R-1)/2.
- R7: The registered path has one cycle of latency. A word taken at one edge shows its result, with `out_valid` high, after that edge. A synchronous reset clears `out_valid` and leaves `in_ready` high. If a result is taken and no new word arrives, `out_valid` falls.
- R8: While `out_valid` is high and `out_ready` is low, `in_ready` is low and every result output holds its value.
- R9: With the maximum number of digits (R+1), all at their largest value, the result is a carry of R-1 and a sum of R-1, with no overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Block can take a word this cycle |
| in_digits | input | NUM_IN*DW | Packed input digits, digit j at bits j*DW +: DW |
| out_valid | output | 1 | Result presented |
| out_ready | input | 1 | Consumer takes the result |
| out_carry | output | DW | Carry digit |
| out_carry_bar | output | DW | Complemented carry digit |
| out_sum | output | DW | Sum digit |
| out_sum_bar | output | DW | Complemented sum digit |
| out_err | output | 1 | Some input digit was out of range |

## Verification
With the registered path, every result field of an accepted word, including `out_err`, is due exactly one rising edge after the edge that takes the word. The bench drives a word on a falling edge and reads the outputs on the next falling edge. By then exactly one register has loaded. In the stall sequence the bench reads `in_ready` and the held outputs on falling edges while `out_ready` is low. It then checks that the waiting word appears one edge after `out_ready` rises, and that `out_valid` clears one edge after the block is drained.

// File: rtl/mvda_pkg.sv
package mvda_pkg;

  // width of one digit field: magnitude bits, plus a sign bit in balanced format
  function automatic int digit_width(input int radix, input bit balanced);
    int w;
    w = $clog2(radix);
    if (w < 1) w = 1;
    return balanced ? w + 1 : w;
  endfunction

  function automatic int digit_lo(input int radix, input bit balanced);
    return balanced ? -((radix - 1) / 2) : 0;
  endfunction

  function automatic int digit_hi(input int radix, input bit balanced);
    return balanced ? (radix - 1) / 2 : radix - 1;
  endfunction

  // threshold of rung g (0-based) on the carry ladder
  function automatic int carry_rung(input int radix, input bit balanced, input int g);
    if (balanced) return radix * (g - (radix - 3) / 2) - (radix - 1) / 2;
    return radix * (g + 1);
  endfunction

  // threshold of rung g (0-based) on the unbalanced sum ladder
  function automatic int sum_rung(input int radix, input int g);
    return radix * radix - radix + g + 1;
  endfunction

endpackage

// File: rtl/mvda_digit_decode.sv
module mvda_digit_decode #(
  parameter int RADIX    = 3,
  parameter int NUM_IN   = 3,
  parameter bit BALANCED = 1'b0,
  parameter int DW       = 2
) (
  input  logic [NUM_IN*DW-1:0] digits,
  output int                   total,
  output logic                 bad
);
  localparam int LO = mvda_pkg::digit_lo(RADIX, BALANCED);
  localparam int HI = mvda_pkg::digit_hi(RADIX, BALANCED);

  int                val [NUM_IN];
  logic [NUM_IN-1:0] oob;

  for (genvar j = 0; j < NUM_IN; j++) begin : g_dig
    if (BALANCED) begin : g_signed
      assign val[j] = int'($signed(digits[j*DW +: DW]));
    end else begin : g_plain
      assign val[j] = int'(digits[j*DW +: DW]);
    end
    assign oob[j] = (val[j] < LO) || (val[j] > HI);
  end

  always_comb begin
    total = 0;
    for (int j = 0; j < NUM_IN; j++) total += val[j];
  end

  assign bad = |oob;
endmodule

// File: rtl/mvda_carry_ladder.sv
module mvda_carry_ladder #(
  parameter int RADIX    = 3,
  parameter bit BALANCED = 1'b0
) (
  input  int total,
  output int carry
);
  localparam int BASE = mvda_pkg::digit_lo(RADIX, BALANCED);

  logic [RADIX-2:0] pass;

  for (genvar g = 0; g < RADIX - 1; g++) begin : g_rung
    assign pass[g] = (total >= mvda_pkg::carry_rung(RADIX, BALANCED, g));
  end

  // thresholds rise monotonically, so the count of passing rungs is the top index
  always_comb begin
    carry = BASE;
    for (int g = 0; g < RADIX - 1; g++) carry += int'(pass[g]);
  end
endmodule

// File: rtl/mvda_sum_stage.sv
module mvda_sum_stage #(
  parameter int RADIX    = 3,
  parameter bit BALANCED = 1'b0
) (
  input  int total,
  input  int carry,
  output int carry_bar,
  output int sum,
  output int sum_bar
);
  if (BALANCED) begin : g_bal
    always_comb begin
      carry_bar = -carry;
      sum       = total + RADIX * carry_bar;
      sum_bar   = -sum;
    end
  end else begin : g_unbal
    int               lifted;
    logic [RADIX-2:0] pass;

    assign carry_bar = RADIX - 1 - carry;
    assign lifted    = total + RADIX * carry_bar;

    for (genvar g = 0; g < RADIX - 1; g++) begin : g_rung
      assign pass[g] = (lifted >= mvda_pkg::sum_rung(RADIX, g));
    end

    always_comb begin
      sum = 0;
      for (int g = 0; g < RADIX - 1; g++) sum += int'(pass[g]);
    end

    assign sum_bar = RADIX - 1 - sum;
  end
endmodule

// File: rtl/mvda_out_reg.sv
module mvda_out_reg #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] d,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] q
);
  logic take;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
    end else if (take) begin
      out_valid <= 1'b1;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (take) q <= d;
  end

  // R7: an accepted word is presented on the next cycle
  p_accept_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> (out_valid && q == $past(d)));

  // R7: a taken result with no new word leaves the stage empty
  p_drain_r7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && !in_valid) |=> !out_valid);

  // R8: a stalled result is held unchanged
  p_stall_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(q)));
endmodule

// File: rtl/mv_digit_adder.sv
module mv_digit_adder
  import mvda_pkg::*;
#(
  parameter int RADIX      = 3,
  parameter int NUM_IN     = 3,
  parameter bit BALANCED   = 1'b0,
  parameter bit REGISTERED = 1'b1,
  localparam int DW        = mvda_pkg::digit_width(RADIX, BALANCED)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [NUM_IN*DW-1:0] in_digits,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [DW-1:0]        out_carry,
  output logic [DW-1:0]        out_carry_bar,
  output logic [DW-1:0]        out_sum,
  output logic [DW-1:0]        out_sum_bar,
  output logic                 out_err
);
  localparam int W  = 4 * DW + 1;
  localparam int LO = digit_lo(RADIX, BALANCED);
  localparam int HI = digit_hi(RADIX, BALANCED);

  if (RADIX < 2) begin : g_chk_radix
    $error("radix must be at least 2");
  end
  if (NUM_IN < 2 || NUM_IN > RADIX + 1) begin : g_chk_count
    $error("digit count must lie in 2..radix+1");
  end
  if (BALANCED && (RADIX % 2 == 0)) begin : g_chk_odd
    $error("balanced format needs an odd radix");
  end

  int   total, carry, carry_bar, sum, sum_bar;
  logic bad;

  mvda_digit_decode #(.RADIX(RADIX), .NUM_IN(NUM_IN), .BALANCED(BALANCED), .DW(DW)) u_decode (
    .digits (in_digits),
    .total  (total),
    .bad    (bad)
  );

  mvda_carry_ladder #(.RADIX(RADIX), .BALANCED(BALANCED)) u_carry (
    .total (total),
    .carry (carry)
  );

  mvda_sum_stage #(.RADIX(RADIX), .BALANCED(BALANCED)) u_sum (
    .total     (total),
    .carry     (carry),
    .carry_bar (carry_bar),
    .sum       (sum),
    .sum_bar   (sum_bar)
  );

  logic [W-1:0] bus_d, bus_q;
  assign bus_d = {bad, DW'(sum_bar), DW'(sum), DW'(carry_bar), DW'(carry)};

  if (REGISTERED) begin : g_reg
    mvda_out_reg #(.W(W)) u_reg (
      .clk       (clk),
      .rst       (rst),
      .in_valid  (in_valid),
      .in_ready  (in_ready),
      .d         (bus_d),
      .out_valid (out_valid),
      .out_ready (out_ready),
      .q         (bus_q)
    );
  end else begin : g_comb
    assign bus_q     = bus_d;
    assign out_valid = in_valid;
    assign in_ready  = out_ready;
  end

  assign {out_err, out_sum_bar, out_sum, out_carry_bar, out_carry} = bus_q;

  // R3 / R5: ladder carry and sum rebuild the decoded total
  p_identity_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !bad) |-> (carry * RADIX + sum == total));

  // R1 / R9: carry stays a legal digit for any legal word
  p_carry_range_r1: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !bad) |-> (carry >= LO && carry <= HI));

  // R4: presented sum and its complement agree
  if (BALANCED) begin : g_a_bal
    p_sum_bar_r4: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !out_err) |-> ($signed(out_sum) == -$signed(out_sum_bar)));
  end else begin : g_a_unbal
    p_sum_bar_r4: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !out_err) |-> (int'(out_sum) + int'(out_sum_bar) == RADIX - 1));
  end
endmodule

// File: tb/mv_digit_adder_test.sv
module mv_digit_adder_test;
  localparam int CLK_PERIOD = 10;
  localparam int UR = 3, UK = 4, UDW = 2;
  localparam int BR = 5, BK = 3, BDW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic [UK*UDW-1:0] u_in = '0;
  logic u_iv = 1'b0, u_or = 1'b1, u_ir, u_ov, u_err;
  logic [UDW-1:0] u_c, u_cb, u_s, u_sb;

  logic [BK*BDW-1:0] b_in = '0;
  logic b_iv = 1'b0, b_or = 1'b1, b_ir, b_ov, b_err;
  logic [BDW-1:0] b_c, b_cb, b_s, b_sb;

  mv_digit_adder #(.RADIX(UR), .NUM_IN(UK), .BALANCED(1'b0), .REGISTERED(1'b1)) uut (
    .clk(clk), .rst(rst), .in_valid(u_iv), .in_ready(u_ir), .in_digits(u_in),
    .out_valid(u_ov), .out_ready(u_or), .out_carry(u_c), .out_carry_bar(u_cb),
    .out_sum(u_s), .out_sum_bar(u_sb), .out_err(u_err));

  mv_digit_adder #(.RADIX(BR), .NUM_IN(BK), .BALANCED(1'b1), .REGISTERED(1'b1)) uut_bal (
    .clk(clk), .rst(rst), .in_valid(b_iv), .in_ready(b_ir), .in_digits(b_in),
    .out_valid(b_ov), .out_ready(b_or), .out_carry(b_c), .out_carry_bar(b_cb),
    .out_sum(b_s), .out_sum_bar(b_sb), .out_err(b_err));

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // unbalanced reference: plain division of the total
  task automatic check_u(input logic [UK*UDW-1:0] v);
    int tot, ec, es;
    bit ill;
    tot = 0; ill = 0;
    for (int j = 0; j < UK; j++) begin
      int d;
      d = int'(v[j*UDW +: UDW]);
      if (d > UR - 1) ill = 1;
      tot += d;
    end
    chk(u_ov == 1'b1, "R7 out_valid", int'(u_ov), 1);
    chk(u_err == ill, "R6 err", int'(u_err), int'(ill));
    if (!ill) begin
      ec = tot / UR;
      es = tot % UR;
      chk(int'(u_c) == ec, "R1 carry", int'(u_c), ec);
      chk(int'(u_cb) == UR - 1 - ec, "R2 carry_bar", int'(u_cb), UR - 1 - ec);
      chk(int'(u_s) == es, "R3 sum", int'(u_s), es);
      chk(int'(u_sb) == UR - 1 - es, "R4 sum_bar", int'(u_sb), UR - 1 - es);
    end
  endtask

  task automatic apply_u(input logic [UK*UDW-1:0] v);
    @(negedge clk);
    u_in = v; u_iv = 1'b1; u_or = 1'b1;
    @(negedge clk);
    u_iv = 1'b0;
    check_u(v);
  endtask

  // balanced reference: floor division after shifting the total positive
  task automatic check_b(input logic [BK*BDW-1:0] v);
    int tot, ec, es, half;
    bit ill;
    half = (BR - 1) / 2;
    tot = 0; ill = 0;
    for (int j = 0; j < BK; j++) begin
      int d;
      d = int'($signed(v[j*BDW +: BDW]));
      if (d < -half || d > half) ill = 1;
      tot += d;
    end
    chk(b_ov == 1'b1, "R7 out_valid balanced", int'(b_ov), 1);
    chk(b_err == ill, "R6 err balanced", int'(b_err), int'(ill));
    if (!ill) begin
      ec = (tot + half + BR * BR) / BR - BR;
      es = tot - BR * ec;
      chk(int'($signed(b_c)) == ec, "R5 carry balanced", int'($signed(b_c)), ec);
      chk(int'($signed(b_s)) == es, "R5 sum balanced", int'($signed(b_s)), es);
      chk(es >= -half && es <= half, "R5 sum range", es, 0);
      chk(int'($signed(b_cb)) == -ec, "R2 carry_bar balanced", int'($signed(b_cb)), -ec);
      chk(int'($signed(b_sb)) == -es, "R4 sum_bar balanced", int'($signed(b_sb)), -es);
    end
  endtask

  task automatic apply_b(input logic [BK*BDW-1:0] v);
    @(negedge clk);
    b_in = v; b_iv = 1'b1; b_or = 1'b1;
    @(negedge clk);
    b_iv = 1'b0;
    check_b(v);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++; checks++;
    $display("FAIL watchdog actual 0 expected 1");
    finish_run();
  end

  initial begin
    logic [UK*UDW-1:0] ua, ub;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R7 reset state
    chk(u_ov == 1'b0, "R7 reset out_valid", int'(u_ov), 0);
    chk(u_ir == 1'b1, "R7 reset in_ready", int'(u_ir), 1);
    chk(b_ov == 1'b0, "R7 reset out_valid balanced", int'(b_ov), 0);

    // directed: R=3 totals 4, 7, 2, and the R9 corner of all-max digits
    apply_u(8'b00_01_01_10);
    chk(int'(u_c) == 1 && int'(u_s) == 1, "R1 total4", int'(u_c), 1);
    apply_u(8'b10_10_10_01);
    chk(int'(u_c) == 2, "R1 total7", int'(u_c), 2);
    apply_u(8'b00_00_01_01);
    chk(int'(u_c) == 0 && int'(u_s) == 2, "R3 total2", int'(u_s), 2);
    apply_u(8'b10_10_10_10);
    chk(int'(u_c) == 2 && int'(u_s) == 2, "R9 all max", int'(u_c), 2);
    apply_u(8'b00_11_00_00);
    chk(u_err == 1'b1, "R6 digit 3 illegal", int'(u_err), 1);

    // exhaustive unbalanced
    for (int w = 0; w < 81; w++) begin
      logic [UK*UDW-1:0] v;
      int t;
      t = w;
      for (int j = 0; j < UK; j++) begin
        v[j*UDW +: UDW] = UDW'(t % 3);
        t = t / 3;
      end
      apply_u(v);
    end

    // exhaustive balanced
    for (int a = -2; a <= 2; a++)
      for (int b = -2; b <= 2; b++)
        for (int c = -2; c <= 2; c++)
          apply_b({4'(c), 4'(b), 4'(a)});
    apply_b({4'sd3, 4'sd0, 4'sd0});
    chk(b_err == 1'b1, "R6 balanced digit 3 illegal", int'(b_err), 1);

    // random words, legal and illegal
    for (int n = 0; n < 300; n++) begin
      apply_u(UK*UDW'($urandom));
      apply_b(BK*BDW'($urandom));
    end

    // R8 back-pressure, then R7 release and drain
    ua = 8'b10_10_10_01;
    ub = 8'b01_01_01_01;
    @(negedge clk);
    u_in = ua; u_iv = 1'b1; u_or = 1'b0;
    @(negedge clk);
    u_in = ub;
    chk(u_ov == 1'b1, "R7 stalled word presented", int'(u_ov), 1);
    chk(u_ir == 1'b0, "R8 in_ready low under stall", int'(u_ir), 0);
    @(negedge clk);
    chk(u_ov == 1'b1 && int'(u_c) == 2 && int'(u_s) == 1, "R8 held carry", int'(u_c), 2);
    chk(int'(u_s) == 1, "R8 held sum", int'(u_s), 1);
    u_or = 1'b1;
    @(negedge clk);
    u_iv = 1'b0;
    check_u(ub);
    @(negedge clk);
    chk(u_ov == 1'b0, "R7 drained", int'(u_ov), 0);

    finish_run();
  end
endmodule